// File: doc/BRIEF.md
# Configuration Image Checker and Restorer

This block checks a 64-byte configuration image kept in a byte-addressed nonvolatile store. On a start pulse it fetches every byte over a single request/acknowledge port. It keeps a local working copy of the bytes and adds bytes 0x00 through 0x3E modulo 256. It then compares that sum with the byte stored at 0x3F. A good checksum with a structure revision of 1 in byte 0x0B gives a pass, and nothing is written.

The restore path starts when the checksum is wrong or when a byte read in the first pass does not complete. The block first adds up its built-in default table, one entry per cycle, and uses that sum as the default value of byte 0x3F. It then walks the addresses in ascending order and writes only the default bytes that differ from the working copy. After a failed read it writes all of them. It then reads the whole image a second time to rebuild the working copy, and checks that copy before it reports.

The host sees busy, a one-cycle done pulse and a held pass flag. It can read any byte of the working copy, and it also gets a decoded bus-reset-enable flag.

Top module: `cfg_image_check`

## Requirements
- R1: A start pulse while idle begins a run, and busy_o is high from the next cycle until the cycle of done_o. A start pulse while busy is ignored, so only one done pulse follows.
- R2: Each byte access holds mem_req_o with a stable mem_addr_o and mem_we_o until mem_ack_i. mem_ack_i is a one-cycle pulse, and read data is taken from mem_rdata_i in that cycle. The first pass reads addresses 0x00 to 0x3F in ascending order.
- R3: The checksum is good when the modulo-256 sum of bytes 0x00..0x3E equals byte 0x3F. A good checksum with byte 0x0B equal to 0x01 gives pass_o=1 and no writes.
- R4: A good checksum with byte 0x0B not equal to 0x01 gives pass_o=0 and no writes.
- R5: A bad checksum starts the restore. Only the addresses whose default byte differs from the read byte are written, in ascending address order. A full second read pass follows, and pass_o is 1 when that pass completes with a good checksum and revision 0x01.
- R6: The defaults are 0x01 at 0x0B, 0x07 at 0x10, 0x83 at 0x11, 0x20 at 0x12, 0x0A at 0x13, and 0xC8 at 0x16..0x25. Every other byte is 0x00, except byte 0x3F, which is the modulo-256 sum of default bytes 0x00..0x3E.
- R7: When mem_ack_i has not arrived in the first TIMEOUT_CYC cycles of a request, mem_req_o drops. A timeout in the first read pass starts the restore with all 64 bytes written. A timeout during a write or during the second read pass ends the run with pass_o=0.
- R8: done_o is high for exactly one cycle. pass_o is valid in that cycle, holds until the next accepted start, and is cleared at that start.
- R9: view_data_o shows the working-copy byte at view_addr_i combinationally. After a run this is the data of the last completed read pass.
- R10: bus_rst_en_o equals bit 0 of working-copy byte 0x11.
- R11: After reset, busy_o, done_o, pass_o and mem_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a check run |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Result of the last run |
| view_addr_i | input | 6 | Working-copy read address |
| view_data_o | output | 8 | Working-copy byte at view_addr_i |
| bus_rst_en_o | output | 1 | Bit 0 of working-copy byte 0x11 |
| mem_req_o | output | 1 | Store access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 6 | Store byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_ack_i | input | 1 | One-cycle access acknowledge |
| mem_rdata_i | input | 8 | Read data, valid with mem_ack_i |

## Verification
The bench builds the block with TIMEOUT_CYC=8. This keeps every timeout short enough that failed reads and failed writes can be forced many times within one run. The store model's acknowledge latency is drawn between zero and TIMEOUT_CYC-2, and the top of that range puts the acknowledge in the last accepted request cycle. Random images include valid images, images with a wrong revision, and lightly perturbed defaults. Together they exercise the no-write path, the fail-without-repair path, and writes that touch only the differing bytes.

// File: rtl/cfg_img_pkg.sv
package cfg_img_pkg;
  localparam int unsigned IMG_BYTES = 64;
  localparam int unsigned ADDR_W    = $clog2(IMG_BYTES);
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned LAST_ADDR = IMG_BYTES - 1;
  localparam int unsigned REV_ADDR  = 11;
  localparam int unsigned CHAN_ADDR = 17;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_GO, S_RD_WAIT, S_EVAL, S_DSUM, S_WR_CMP, S_WR_WAIT, S_FIN
  } ctl_state_e;

  // default image, byte LAST_ADDR excluded (checksum is summed in hardware)
  function automatic logic [BYTE_W-1:0] default_byte(input logic [ADDR_W-1:0] a);
    case (a) inside
      6'h0B:          return 8'h01;
      6'h10:          return 8'h07;
      6'h11:          return 8'h83;
      6'h12:          return 8'h20;
      6'h13:          return 8'h0A;
      [6'h16:6'h25]:  return 8'hC8;
      default:        return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfg_byte_port.sv
module cfg_byte_port #(
  parameter int unsigned AW          = 6,
  parameter int unsigned DW          = 8,
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ok_o,
  output logic          tmo_o,
  output logic [DW-1:0] rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);

  logic          busy_q, ok_q, tmo_q, we_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; ok_q <= 1'b0; tmo_q <= 1'b0; we_q <= 1'b0;
      cnt_q <= '0; addr_q <= '0; wdata_q <= '0; rdata_q <= '0;
    end else begin
      ok_q  <= 1'b0;
      tmo_q <= 1'b0;
      if (!busy_q) begin
        if (go_i) begin
          busy_q  <= 1'b1;
          cnt_q   <= '0;
          we_q    <= we_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
        end
      end else if (mem_ack_i) begin
        busy_q  <= 1'b0;
        ok_q    <= 1'b1;
        rdata_q <= mem_rdata_i;
      end else if (cnt_q == CW'(TIMEOUT_CYC - 1)) begin
        busy_q <= 1'b0;
        tmo_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ok_o        = ok_q;
  assign tmo_o       = tmo_q;
  assign rdata_o     = rdata_q;
  assign mem_req_o   = busy_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/cfg_copy_ram.sv
module cfg_copy_ram #(
  parameter int unsigned N  = 64,
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [AW-1:0]   raddr_i,
  output logic [DW-1:0]   rdata_o,
  output logic [N*DW-1:0] img_o
);
  logic [DW-1:0] mem_q [N];

  for (genvar g = 0; g < N; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))      mem_q[g] <= wdata_i;
    end
    assign img_o[g*DW +: DW] = mem_q[g];
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cfg_image_check.sv
module cfg_image_check
  import cfg_img_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        pass_o,
  input  logic [5:0]  view_addr_i,
  output logic [7:0]  view_data_o,
  output logic        bus_rst_en_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [5:0]  mem_addr_o,
  output logic [7:0]  mem_wdata_o,
  input  logic        mem_ack_i,
  input  logic [7:0]  mem_rdata_i
);
  localparam int unsigned AW = ADDR_W;
  localparam int unsigned DW = BYTE_W;
  localparam logic [AW-1:0] LAST = AW'(LAST_ADDR);

  ctl_state_e state_q;
  logic [AW-1:0] idx_q;
  logic [DW-1:0] sum_q, dsum_q;
  logic          pass2_q, force_q, pass_q;

  logic          port_go, port_ok, port_tmo;
  logic [DW-1:0] port_rdata, cur_b, def_b;
  logic [IMG_BYTES*DW-1:0] img_w;
  logic          differ, ck_ok, rev_ok;

  assign cur_b  = img_w[idx_q*DW +: DW];
  assign def_b  = (idx_q == LAST) ? dsum_q : default_byte(idx_q);
  assign differ = force_q || (def_b != cur_b);
  assign ck_ok  = sum_q == img_w[LAST_ADDR*DW +: DW];
  assign rev_ok = img_w[REV_ADDR*DW +: DW] == 8'h01;
  assign port_go = (state_q == S_RD_GO) || (state_q == S_WR_CMP && differ);

  cfg_byte_port #(.AW(AW), .DW(DW), .TIMEOUT_CYC(TIMEOUT_CYC)) u_port (
    .clk_i, .rst_ni,
    .go_i(port_go), .we_i(state_q == S_WR_CMP), .addr_i(idx_q), .wdata_i(def_b),
    .ok_o(port_ok), .tmo_o(port_tmo), .rdata_o(port_rdata),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i
  );

  cfg_copy_ram #(.N(IMG_BYTES), .AW(AW), .DW(DW)) u_copy (
    .clk_i, .rst_ni,
    .we_i(state_q == S_RD_WAIT && port_ok), .waddr_i(idx_q), .wdata_i(port_rdata),
    .raddr_i(view_addr_i), .rdata_o(view_data_o), .img_o(img_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; idx_q <= '0; sum_q <= '0; dsum_q <= '0;
      pass2_q <= 1'b0; force_q <= 1'b0; pass_q <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          pass_q <= 1'b0; idx_q <= '0; sum_q <= '0;
          pass2_q <= 1'b0; force_q <= 1'b0;
          state_q <= S_RD_GO;
        end
        S_RD_GO: state_q <= S_RD_WAIT;
        S_RD_WAIT: begin
          if (port_ok) begin
            if (idx_q != LAST) begin
              sum_q   <= sum_q + port_rdata;
              idx_q   <= idx_q + 1'b1;
              state_q <= S_RD_GO;
            end else begin
              state_q <= S_EVAL;
            end
          end else if (port_tmo) begin
            if (pass2_q) begin
              pass_q  <= 1'b0;
              state_q <= S_FIN;
            end else begin
              force_q <= 1'b1;   // copy is incomplete: rewrite every byte
              idx_q   <= '0;
              dsum_q  <= '0;
              state_q <= S_DSUM;
            end
          end
        end
        S_EVAL: begin
          if (!ck_ok && !pass2_q) begin
            idx_q   <= '0;
            dsum_q  <= '0;
            state_q <= S_DSUM;
          end else begin
            pass_q  <= ck_ok && rev_ok;
            state_q <= S_FIN;
          end
        end
        S_DSUM: begin
          dsum_q <= dsum_q + default_byte(idx_q);
          if (idx_q == LAST - 1'b1) begin
            idx_q   <= '0;
            state_q <= S_WR_CMP;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_WR_CMP: begin
          if (differ) begin
            state_q <= S_WR_WAIT;
          end else if (idx_q == LAST) begin
            idx_q <= '0; sum_q <= '0; pass2_q <= 1'b1; state_q <= S_RD_GO;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_WR_WAIT: begin
          if (port_ok) begin
            if (idx_q == LAST) begin
              idx_q <= '0; sum_q <= '0; pass2_q <= 1'b1; state_q <= S_RD_GO;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= S_WR_CMP;
            end
          end else if (port_tmo) begin
            pass_q  <= 1'b0;
            state_q <= S_FIN;
          end
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o       = state_q != S_IDLE;
  assign done_o       = state_q == S_FIN;
  assign pass_o       = pass_q;
  assign bus_rst_en_o = img_w[CHAN_ADDR*DW];
endmodule

// File: rtl/cfg_image_check_sva.sv
module cfg_image_check_sva #(
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       pass_o,
  input logic       mem_req_o,
  input logic       mem_we_o,
  input logic [5:0] mem_addr_o,
  input logic       mem_ack_i
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 2);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     run_q <= '0;
    else if (mem_req_o && !mem_ack_i) run_q <= run_q + 1'b1;
    else                             run_q <= '0;
  end

  assert_start_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);
  assert_req_in_run_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> $stable(mem_addr_o) && $stable(mem_we_o));
  assert_req_limit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> run_q < CW'(TIMEOUT_CYC));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  assert_pass_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_o) |-> done_o);
endmodule

bind cfg_image_check cfg_image_check_sva #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .pass_o(pass_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i)
);

// File: tb/cfg_image_check_tb.sv
`timescale 1ns/1ps
module cfg_image_check_tb;
  localparam int unsigned TMO = 8;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic busy_o, done_o, pass_o, bus_rst_en_o;
  logic [5:0] view_addr = '0;
  logic [7:0] view_data;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [5:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = '0;

  always #2.5 clk = ~clk;

  cfg_image_check #(.TIMEOUT_CYC(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .pass_o(pass_o), .view_addr_i(view_addr), .view_data_o(view_data),
    .bus_rst_en_o(bus_rst_en_o), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata)
  );

  // behavioural store
  logic [7:0] mem_q [64];
  logic [7:0] load_img [64];
  logic       load_req = 1'b0;
  int         lat = 0, lat_cnt = 0, dead_cfg = 0, dead_left = 0;
  logic [5:0] dead_addr = '0;
  logic       dead_we = 1'b0, refused_q = 1'b0, order_bad = 1'b0;
  logic [63:0] wr_mask = '0;
  int         wr_cnt = 0;
  logic [5:0] last_wr = '0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (load_req) begin
      for (int i = 0; i < 64; i++) mem_q[i] <= load_img[i];
      wr_mask <= '0; wr_cnt <= 0; order_bad <= 1'b0; dead_left <= dead_cfg;
      refused_q <= 1'b0; lat_cnt <= 0;
    end else if (mem_req && !mem_ack) begin
      if (dead_left > 0 && mem_addr == dead_addr && mem_we == dead_we) begin
        refused_q <= 1'b1;
      end else if (lat_cnt == lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem_q[mem_addr];
        lat_cnt   <= 0;
        if (mem_we) begin
          mem_q[mem_addr] <= mem_wdata;
          if (wr_mask[mem_addr] || (wr_cnt > 0 && mem_addr <= last_wr)) order_bad <= 1'b1;
          wr_mask[mem_addr] <= 1'b1;
          wr_cnt  <= wr_cnt + 1;
          last_wr <= mem_addr;
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      lat_cnt <= 0;
      if (!mem_req && refused_q) begin
        refused_q <= 1'b0;
        dead_left <= dead_left - 1;
      end
    end
  end

  int total = 0, bad = 0;
  logic [7:0] t_img [64];
  logic [7:0] exp_copy [64];
  logic [7:0] exp_mem [64];
  logic [63:0] exp_mask;
  logic exp_pass, chk_detail;

  task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] dflt(input int a);
    logic [7:0] s;
    if (a == 11) return 8'h01;
    if (a == 16) return 8'h07;
    if (a == 17) return 8'h83;
    if (a == 18) return 8'h20;
    if (a == 19) return 8'h0A;
    if (a >= 22 && a <= 37) return 8'hC8;
    if (a == 63) begin
      s = 0;
      for (int i = 0; i < 63; i++) s = s + dflt(i);
      return s;
    end
    return 8'h00;
  endfunction

  function automatic logic [7:0] sum63();
    logic [7:0] s = 0;
    for (int i = 0; i < 63; i++) s = s + t_img[i];
    return s;
  endfunction

  // mode 0: all accesses complete; 1: first-pass read fails once; 2: run must fail
  task automatic model(input int mode);
    bit ck;
    ck = sum63() == t_img[63];
    chk_detail = mode != 2;
    if (mode == 2) begin
      exp_pass = 1'b0;
    end else if (mode == 0 && ck) begin
      exp_pass = t_img[11] == 8'h01;
      exp_mask = '0;
      for (int i = 0; i < 64; i++) begin exp_copy[i] = t_img[i]; exp_mem[i] = t_img[i]; end
    end else begin
      exp_pass = 1'b1;
      for (int i = 0; i < 64; i++) begin
        exp_mask[i] = (mode == 1) || (dflt(i) != t_img[i]);
        exp_copy[i] = dflt(i);
        exp_mem[i]  = dflt(i);
      end
    end
  endtask

  task automatic run_case(input string name, input int mode, input bit restart);
    bit seen = 0, got_pass = 0;
    model(mode);
    @(negedge clk);
    for (int i = 0; i < 64; i++) load_img[i] = t_img[i];
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    start_i  = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, {"R1 busy after start ", name}, busy_o, 1);
    chk(!pass_o, {"R8 pass cleared at start ", name}, pass_o, 0);
    for (int c = 0; c < 20000 && !seen; c++) begin
      @(negedge clk);
      start_i = restart && (c == 20);
      if (done_o) begin seen = 1; got_pass = pass_o; end
    end
    start_i = 1'b0;
    chk(seen, {"R8 done seen ", name}, seen, 1);
    chk(got_pass == exp_pass, {"R3 R4 R5 R7 result ", name}, got_pass, exp_pass);
    @(negedge clk);
    chk(!done_o, {"R8 done one cycle ", name}, done_o, 0);
    chk(pass_o == got_pass, {"R8 pass held ", name}, pass_o, got_pass);
    chk(!busy_o, {"R1 idle after done ", name}, busy_o, 0);
    if (restart) begin
      repeat (3) @(negedge clk);
      chk(!busy_o && !done_o, {"R1 start while busy ignored ", name}, busy_o, 0);
    end
    if (chk_detail) begin
      chk(wr_mask == exp_mask, {"R5 R7 written set ", name}, wr_mask, exp_mask);
      chk(!order_bad, {"R5 ascending writes ", name}, order_bad, 0);
      for (int i = 0; i < 64; i++)
        chk(mem_q[i] == exp_mem[i], {"R6 stored image ", name}, mem_q[i], exp_mem[i]);
      for (int i = 0; i < 64; i++) begin
        view_addr = 6'(i);
        #0.5;
        chk(view_data == exp_copy[i], {"R9 working copy ", name}, view_data, exp_copy[i]);
      end
      chk(bus_rst_en_o == exp_copy[17][0], {"R10 bus reset flag ", name}, bus_rst_en_o, exp_copy[17][0]);
    end
  endtask

  task automatic fill_valid(input bit good_rev);
    for (int i = 0; i < 63; i++) t_img[i] = 8'($urandom);
    t_img[11] = good_rev ? 8'h01 : 8'(2 + $urandom % 200);
    t_img[63] = sum63();
  endtask

  initial begin
    repeat (100000 / 3) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !pass_o && !mem_req, "R11 reset state", {busy_o, done_o, pass_o, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: defaults already stored, slowest accepted latency
    lat = TMO - 2;
    for (int i = 0; i < 64; i++) t_img[i] = dflt(i);
    run_case("R6 defaults intact", 0, 0);
    // all-zero image: checksum good, revision 0
    lat = 0;
    for (int i = 0; i < 64; i++) t_img[i] = 8'h00;
    run_case("R4 zero image", 0, 0);
    // zero image with bad checksum: restore from scratch
    t_img[0] = 8'h05;
    run_case("R5 restore from zero", 0, 1);
    // first-pass read timeout
    lat = 1; dead_cfg = 1; dead_addr = 6'h20; dead_we = 1'b0;
    for (int i = 0; i < 64; i++) t_img[i] = dflt(i);
    run_case("R7 read timeout first pass", 1, 0);
    // read timeout in both passes
    dead_cfg = 2;
    run_case("R7 read timeout both passes", 2, 0);
    // write timeout
    dead_cfg = 1; dead_addr = 6'h10; dead_we = 1'b1;
    for (int i = 0; i < 64; i++) t_img[i] = 8'h00;
    t_img[0] = 8'h05;
    run_case("R7 write timeout", 2, 0);
    dead_cfg = 0;

    for (int n = 0; n < 24; n++) begin
      int kind = n % 4;
      lat = $urandom % (TMO - 1);
      case (kind)
        0: fill_valid(1);
        1: fill_valid(0);
        2: begin fill_valid(1); t_img[63] = t_img[63] + 8'(1 + $urandom % 255); end
        default: begin
          for (int i = 0; i < 64; i++) t_img[i] = dflt(i);
          for (int k = 0; k < 1 + $urandom % 3; k++) begin
            int a = $urandom % 63;
            t_img[a] = t_img[a] ^ 8'(1 + $urandom % 255);
          end
          if (sum63() == t_img[63]) t_img[63] = t_img[63] + 8'h01;
        end
      endcase
      run_case($sformatf("random kind %0d R3 R5", kind), 0, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule